// File: doc/BRIEF.md
# RTC Date Snapshot Sequencer

This block runs whole-date transactions against an external real-time clock chip. It sits above a serial register engine that handles the bit timing on the wire. A start request runs a bring-up sequence. First it sends single-bit dummy reads so that the chip waits for a fresh transfer. Then it writes a fixed test byte into the seconds register and reads it back to confirm that a chip is present. If the byte comes back intact, it clears the chip's status register.

A get request first freezes the running clock into the chip's holding registers. It then reads back seven BCD fields and presents them as binary values. A set request latches the binary fields from the user, converts each one to two-digit BCD and writes them all. It then commits the holding registers to the running clock.

Each transaction is split into single operations for the engine. For every operation the block raises a one-cycle request and then waits for the engine's completion strobe before it moves on. The last result is reported with a one-cycle done pulse and an error flag.

Top module: `rtc_snap_seq`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, err_o and eng_req_o are all low and time_o is zero.
- R2: Requests are taken only while idle, and a request that arrives while busy has no effect. When several requests arrive in the same idle cycle, start beats set, and set beats get.
- R3: Engine operation codes on eng_op_o are 0 for a single-bit read, 1 for a register write, 2 for a register read and 3 for a command. A start sequence begins with exactly 8 single-bit reads, before any other operation.
- R4: After the dummy reads, a start sequence writes 0x33 to the seconds register (default address 2) and reads that register back. Any other value ends the sequence with done_o and err_o both high, and no further operation is issued.
- R5: When the read-back matches, the sequence writes 0x00 to the status register (default address 0) and ends with err_o low. A start sequence therefore issues 11 operations.
- R6: A get issues the latch command first (address field 0xC by default). It then reads seconds, minutes, hours, day of month, month, weekday and year, in that order, from default addresses 2 through 8.
- R7: A get decodes each BCD byte to binary. The month is returned as the chip value minus one. Field k of time_o and time_i occupies bits [7k+6:7k], with k running 0..6 in the order given in R6.
- R8: A set writes the same seven registers in the same order as two-digit BCD. The month is written as the user value plus one and the year as the user value modulo 100. The set then issues the commit command (address field 0xD by default).
- R9: done_o is a one-cycle pulse in the cycle after the engine's final completion strobe. err_o is high only together with done_o, and only on a failed presence check.
- R10: eng_req_o is a single-cycle pulse, and no new request is issued until the engine has signalled completion of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Start the bring-up sequence |
| get_i | input | 1 | Read the date from the chip |
| set_i | input | 1 | Write the date to the chip |
| time_i | input | 49 | Binary fields to write, 7 bits each |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | Transaction finished (one-cycle pulse) |
| err_o | output | 1 | Chip not present, valid with done_o |
| time_o | output | 49 | Binary date fields held by the block |
| eng_req_o | output | 1 | Operation request pulse to the engine |
| eng_op_o | output | 2 | Operation code for the engine |
| eng_addr_o | output | 4 | Register address or command code |
| eng_wdata_o | output | 8 | Byte to write |
| eng_done_i | input | 1 | Engine completion strobe |
| eng_rdata_i | input | 8 | Byte returned by a register read |

## Verification
The done pulse and the fields on time_o are due exactly one cycle after the engine model's final completion strobe. The bench records the cycle of every strobe and compares it with the cycle in which done_o is seen. The engine model answers each request after a random delay of one to four cycles, so no check can rely on a fixed transaction length. All other results are read only after the done pulse: the operation log, the model's clock registers and time_o.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int NF = 7;        // date fields per transaction
  localparam int IDX_MON = 4;
  localparam int IDX_YEAR = 6;

  typedef enum logic [1:0] {
    OP_BITRD = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_CMD   = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {M_INIT, M_GET, M_SET} mode_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
endpackage

// File: rtl/rtc_bin2bcd.sv
module rtc_bin2bcd #(
  parameter int FW = 7
) (
  input  logic [FW-1:0] bin_i,
  output logic [7:0]    bcd_o
);
  logic [7:0] b8, tens, ones;
  assign b8   = 8'(bin_i);
  assign tens = b8 / 8'd10;
  assign ones = b8 - tens * 8'd10;
  assign bcd_o = (tens << 4) | ones;
endmodule

// File: rtl/rtc_bcd2bin.sv
module rtc_bcd2bin #(
  parameter int FW = 7
) (
  input  logic [7:0]    bcd_i,
  output logic [FW-1:0] bin_o
);
  logic [7:0] sum;
  assign sum   = {4'b0, bcd_i[7:4]} * 8'd10 + {4'b0, bcd_i[3:0]};
  assign bin_o = FW'(sum);
endmodule

// File: rtl/rtc_snap_seq.sv
module rtc_snap_seq
  import rtc_snap_pkg::*;
#(
  parameter int          FW         = 7,
  parameter int          AW         = 4,
  parameter int          NSYNC      = 8,
  parameter logic [7:0]  TEST_PAT   = 8'h33,
  parameter logic [AW-1:0] A_STAT   = 4'h0,
  parameter logic [AW-1:0] A_SEC    = 4'h2,
  parameter logic [AW-1:0] A_MIN    = 4'h3,
  parameter logic [AW-1:0] A_HOUR   = 4'h4,
  parameter logic [AW-1:0] A_MDAY   = 4'h5,
  parameter logic [AW-1:0] A_MON    = 4'h6,
  parameter logic [AW-1:0] A_WDAY   = 4'h7,
  parameter logic [AW-1:0] A_YEAR   = 4'h8,
  parameter logic [AW-1:0] CMD_LATCH  = 4'hC,
  parameter logic [AW-1:0] CMD_COMMIT = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             get_i,
  input  logic             set_i,
  input  logic [NF*FW-1:0] time_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [NF*FW-1:0] time_o,
  output logic             eng_req_o,
  output logic [1:0]       eng_op_o,
  output logic [AW-1:0]    eng_addr_o,
  output logic [7:0]       eng_wdata_o,
  input  logic             eng_done_i,
  input  logic [7:0]       eng_rdata_i
);
  localparam int SW = $clog2(NSYNC + NF + 4);
  localparam logic [SW-1:0] ST_WR_PAT = SW'(NSYNC);
  localparam logic [SW-1:0] ST_RD_PAT = SW'(NSYNC + 1);

  st_e             st_q;
  mode_e           mode_q;
  logic [SW-1:0]   step_q;
  logic            done_q, err_q;
  logic [FW-1:0]   fld_q [NF];
  logic [7:0]      enc [NF];
  logic [FW-1:0]   dec;
  logic [2:0]      fidx;
  logic [7:0]      wsel;
  eng_op_e         op;
  logic [AW-1:0]   addr;
  logic [7:0]      wdata;
  logic            last;

  function automatic logic [AW-1:0] faddr(input logic [2:0] i);
    case (i)
      3'd0: faddr = A_SEC;
      3'd1: faddr = A_MIN;
      3'd2: faddr = A_HOUR;
      3'd3: faddr = A_MDAY;
      3'd4: faddr = A_MON;
      3'd5: faddr = A_WDAY;
      default: faddr = A_YEAR;
    endcase
  endfunction

  // per-field write adjustment and encoding
  for (genvar k = 0; k < NF; k++) begin : g_enc
    logic [FW-1:0] adj;
    if (k == IDX_MON) begin : g_mon
      assign adj = fld_q[k] + FW'(1);
    end else if (k == IDX_YEAR) begin : g_year
      assign adj = fld_q[k] % FW'(100);
    end else begin : g_plain
      assign adj = fld_q[k];
    end
    rtc_bin2bcd #(.FW(FW)) u_enc (.bin_i(adj), .bcd_o(enc[k]));
    assign time_o[k*FW +: FW] = fld_q[k];
  end

  rtc_bcd2bin #(.FW(FW)) u_dec (.bcd_i(eng_rdata_i), .bin_o(dec));

  assign fidx = (mode_q == M_GET) ? 3'(step_q - SW'(1)) : 3'(step_q);

  always_comb begin
    wsel = '0;
    for (int k = 0; k < NF; k++) if (fidx == 3'(k)) wsel = enc[k];
  end

  // operation decode from mode and step
  always_comb begin
    op = OP_CMD; addr = '0; wdata = '0; last = 1'b0;
    unique case (mode_q)
      M_INIT: begin
        if (step_q < ST_WR_PAT) op = OP_BITRD;
        else if (step_q == ST_WR_PAT) begin op = OP_WRITE; addr = A_SEC; wdata = TEST_PAT; end
        else if (step_q == ST_RD_PAT) begin op = OP_READ; addr = A_SEC; end
        else begin op = OP_WRITE; addr = A_STAT; last = 1'b1; end
      end
      M_GET: begin
        if (step_q == '0) begin op = OP_CMD; addr = CMD_LATCH; end
        else begin op = OP_READ; addr = faddr(fidx); end
        last = (step_q == SW'(NF));
      end
      default: begin
        if (step_q < SW'(NF)) begin op = OP_WRITE; addr = faddr(fidx); wdata = wsel; end
        else begin op = OP_CMD; addr = CMD_COMMIT; last = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; mode_q <= M_INIT; step_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
      for (int k = 0; k < NF; k++) fld_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          step_q <= '0;
          if (init_i) begin
            mode_q <= M_INIT; st_q <= S_ISSUE;
          end else if (set_i) begin
            mode_q <= M_SET; st_q <= S_ISSUE;
            for (int k = 0; k < NF; k++) fld_q[k] <= time_i[k*FW +: FW];
          end else if (get_i) begin
            mode_q <= M_GET; st_q <= S_ISSUE;
          end
        end
        S_ISSUE: st_q <= S_WAIT;
        default: if (eng_done_i) begin
          if (mode_q == M_GET && op == OP_READ)
            for (int k = 0; k < NF; k++)
              if (fidx == 3'(k)) fld_q[k] <= (k == IDX_MON) ? dec - FW'(1) : dec;
          if (mode_q == M_INIT && step_q == ST_RD_PAT && eng_rdata_i != TEST_PAT) begin
            st_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1;
          end else if (last) begin
            st_q <= S_IDLE; done_q <= 1'b1;
          end else begin
            step_q <= step_q + SW'(1); st_q <= S_ISSUE;
          end
        end
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign eng_req_o   = (st_q == S_ISSUE);
  assign eng_op_o    = op;
  assign eng_addr_o  = addr;
  assign eng_wdata_o = wdata;

  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |=> !eng_req_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R2
  start_by_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(init_i || get_i || set_i));
  // R8
  year_bcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && mode_q == M_SET && eng_addr_o == A_YEAR && eng_op_o == OP_WRITE)
      |-> (eng_wdata_o[7:4] <= 4'd9 && eng_wdata_o[3:0] <= 4'd9));
endmodule

// File: tb/sim_rtc_snap_seq.sv
`timescale 1ns/1ps
module sim_rtc_snap_seq;
  localparam int NF = 7, FW = 7;

  logic clk = 0, rst_ni = 0;
  logic init_i = 0, get_i = 0, set_i = 0;
  logic [NF*FW-1:0] time_i = '0, time_o;
  logic busy_o, done_o, err_o, eng_req_o, eng_done_i = 0;
  logic [1:0] eng_op_o;
  logic [3:0] eng_addr_o;
  logic [7:0] eng_wdata_o, eng_rdata_i = 0;

  always #2 clk = ~clk;

  rtc_snap_seq u0 (.*, .clk_i(clk));

  int total = 0, bad = 0, cyc = 0, done_cyc = -10;
  logic [7:0] ram [16];
  logic [7:0] clkr [16];
  bit present = 1, overlap = 0;
  int nlog = 0;
  logic [1:0] op_log [64];
  logic [3:0] addr_log [64];

  always @(posedge clk) cyc++;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  task automatic chk(input string rq, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", rq, act, exp); end
  endtask

  // engine model with random latency
  initial begin : engine
    bit pend = 0; int cnt = 0;
    logic [1:0] op; logic [3:0] a; logic [7:0] wd;
    forever begin
      @(negedge clk);
      eng_done_i = 0;
      if (pend) begin
        if (eng_req_o) overlap = 1;
        if (cnt == 0) begin
          case (op)
            2'd1: ram[a] = wd;
            2'd2: eng_rdata_i = present ? ram[a] : 8'hFF;
            2'd3: for (int k = 2; k < 9; k++)
                    if (a == 4'hC) ram[k] = clkr[k]; else clkr[k] = ram[k];
            default: ;
          endcase
          eng_done_i = 1; done_cyc = cyc; pend = 0;
        end else cnt--;
      end else if (eng_req_o) begin
        pend = 1; cnt = $urandom_range(0, 3);
        op = eng_op_o; a = eng_addr_o; wd = eng_wdata_o;
        if (nlog < 64) begin op_log[nlog] = op; addr_log[nlog] = a; end
        nlog++;
      end
    end
  end

  task automatic run(input bit i, input bit g, input bit s, output bit e);
    int t = 0;
    nlog = 0;
    @(negedge clk); init_i = i; get_i = g; set_i = s;
    @(negedge clk); init_i = 0; get_i = 0; set_i = 0;
    while (!done_o && t < 3000) begin @(negedge clk); t++; end
    chk("R9 done latency", done_o && cyc == done_cyc + 1, cyc, done_cyc + 1);
    e = err_o;
    @(negedge clk);
    chk("R9 done one cycle", !done_o, done_o, 0);
  endtask

  task automatic do_set(input int f [NF]);
    bit e;
    for (int k = 0; k < NF; k++) time_i[k*FW +: FW] = FW'(f[k]);
    run(0, 0, 1, e);
    chk("R9 set err", !e, e, 0);
    chk("R8 op count", nlog == 8, nlog, 8);
    for (int k = 0; k < NF; k++) begin
      int v = (k == 4) ? f[k] + 1 : (k == 6) ? f[k] % 100 : f[k];
      chk("R8 field bcd", clkr[2+k] == to_bcd(v), clkr[2+k], to_bcd(v));
      chk("R8 order", op_log[k] == 2'd1 && addr_log[k] == 4'(2 + k), addr_log[k], 2 + k);
    end
    chk("R8 commit last", op_log[7] == 2'd3 && addr_log[7] == 4'hD, addr_log[7], 4'hD);
  endtask

  task automatic do_get();
    bit e;
    run(0, 1, 0, e);
    chk("R9 get err", !e, e, 0);
    chk("R6 latch first", op_log[0] == 2'd3 && addr_log[0] == 4'hC, addr_log[0], 4'hC);
    for (int k = 0; k < NF; k++) begin
      int ex = from_bcd(clkr[2+k]) - ((k == 4) ? 1 : 0);
      chk("R6 read order", op_log[k+1] == 2'd2 && addr_log[k+1] == 4'(2 + k), addr_log[k+1], 2 + k);
      chk("R7 field", time_o[k*FW +: FW] == FW'(ex), time_o[k*FW +: FW], FW'(ex));
    end
  endtask

  task automatic rand_clk();
    clkr[2] = to_bcd($urandom_range(0, 59)); clkr[3] = to_bcd($urandom_range(0, 59));
    clkr[4] = to_bcd($urandom_range(0, 23)); clkr[5] = to_bcd($urandom_range(1, 31));
    clkr[6] = to_bcd($urandom_range(1, 12)); clkr[7] = to_bcd($urandom_range(0, 6));
    clkr[8] = to_bcd($urandom_range(0, 99));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit e;
    int f [NF];
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) begin ram[k] = 8'hA5; clkr[k] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", !busy_o, busy_o, 0);
    chk("R1 done/err", !done_o && !err_o, {done_o, err_o}, 0);
    chk("R1 req", !eng_req_o, eng_req_o, 0);
    chk("R1 time", time_o == '0, 0, 0);
    rst_ni = 1;

    // R4 absent chip
    present = 0;
    run(1, 0, 0, e);
    chk("R4 err flag", e, e, 1);
    chk("R4 stops", nlog == 10, nlog, 10);
    chk("R4 status untouched", ram[0] == 8'hA5, ram[0], 8'hA5);
    chk("R4 pattern write", op_log[8] == 2'd1 && addr_log[8] == 4'h2 && ram[2] == 8'h33, ram[2], 8'h33);

    // R3 R5 present chip
    present = 1; ram[0] = 8'hA5;
    run(1, 0, 0, e);
    chk("R5 no err", !e, e, 0);
    chk("R5 op count", nlog == 11, nlog, 11);
    for (int k = 0; k < 8; k++) chk("R3 bit reads", op_log[k] == 2'd0, op_log[k], 0);
    chk("R5 status cleared", ram[0] == 8'h00 && addr_log[10] == 4'h0, ram[0], 0);

    // R6 R7 directed get
    clkr[2] = 8'h59; clkr[3] = 8'h00; clkr[4] = 8'h23; clkr[5] = 8'h31;
    clkr[6] = 8'h12; clkr[7] = 8'h06; clkr[8] = 8'h99;
    do_get();

    // R8 corner set: year 127 wraps to 27, month 11 -> 12
    f = '{0, 0, 0, 1, 11, 0, 127};
    do_set(f);
    f = '{59, 59, 23, 31, 0, 6, 99};
    do_set(f);

    // R2 request during busy ignored
    rand_clk();
    nlog = 0;
    @(negedge clk); get_i = 1;
    @(negedge clk); get_i = 0;
    @(negedge clk); @(negedge clk);
    time_i = '1; set_i = 1; init_i = 1;
    @(negedge clk); set_i = 0; init_i = 0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk("R2 busy ignore count", nlog == 8, nlog, 8);
    chk("R2 busy ignore op", op_log[0] == 2'd3, op_log[0], 3);
    chk("R2 field kept", time_o[0 +: FW] == FW'(from_bcd(clkr[2])), time_o[0 +: FW], from_bcd(clkr[2]));
    @(negedge clk);
    chk("R2 no late start", !busy_o, busy_o, 0);

    // R2 priority init > set > get
    run(1, 1, 1, e);
    chk("R2 priority init", nlog == 11 && op_log[0] == 2'd0, nlog, 11);
    time_i = '0;
    run(0, 1, 1, e);
    chk("R2 priority set", nlog == 8 && op_log[7] == 2'd3 && addr_log[7] == 4'hD, addr_log[7], 4'hD);

    // random round trips
    for (int n = 0; n < 20; n++) begin
      f = '{$urandom_range(0, 59), $urandom_range(0, 59), $urandom_range(0, 23),
            $urandom_range(1, 31), $urandom_range(0, 11), $urandom_range(0, 6),
            $urandom_range(0, 127)};
      do_set(f);
      for (int k = 2; k < 9; k++) ram[k] = 8'hEE;
      do_get();
      chk("R7 year roundtrip", time_o[6*FW +: FW] == FW'(f[6] % 100), time_o[6*FW +: FW], f[6] % 100);
      rand_clk();
      do_get();
    end

    chk("R10 no overlapping request", !overlap, overlap, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule